// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Core

This block is a synthesizable model of a synchronous static memory whose data bus runs at double data rate and which always transfers two words per command. One address bus carries commands. A command is taken on the rising edge of the input clock `k` when the load strobe is low, and a direction select marks it as a read or a write. Write words and their active-low lane masks are taken on the rising edge of `k` and then on the rising edge of `k_n`. Read words leave on the rising edges of the output clock pair `c`/`c_n`. With `SINGLE_CLK` set, they leave on `k`/`k_n` instead. A small parameterized array stands in for the memory cells.

The two words of a burst sit at a pair of addresses that differ only in bit 0. In the default layout, the external address bit 0 chooses which word of the pair goes first, and the second word uses the other value of that bit. With `ZERO_START` set, the external address has no bit 0 and every burst starts at the even word. Each lane mask bit guards one lane of `LANE_W` bits. The bench uses lanes of 9 bits for the wide layout and lanes of 4 bits for the narrow layout.

Top module: `burst2_ddr_sram`

## Requirements
- R1: A command is taken only at a rising edge of `k` with `ld_n` low. A `k` edge with `ld_n` high starts nothing: no write changes the array and no read drives the bus.
- R2: For a taken command, `rw` high means read and `rw` low means write.
- R3: At the `k` edge right after a taken command, `ld_n` is ignored, so two bursts never overlap and commands are at least two `k` cycles apart.
- R4: For a write taken at `k` edge n, word 0 is sampled from `d` at `k` edge n+1 and word 1 is sampled at the `k_n` rising edge half a cycle later. Values on `d` at other edges have no effect.
- R5: When `ZERO_START`=0, word 0 is stored at and read from the internal address A. Word 1 uses A with bit 0 inverted, for both odd and even A.
- R6: When `ZERO_START`=1, the external address is one bit narrower and supplies internal bits ADDR_W-1..1. Word 0 uses internal bit 0 = 0 and word 1 uses bit 0 = 1.
- R7: `wmask_n[i]` is active low and guards bits [i*LANE_W +: LANE_W]. It is sampled on the same edge as the data word it masks. A lane whose mask bit is 1 keeps its stored value.
- R8: For a read taken at `k` edge n, word 0 is on `q` from the output-low-clock rising edge at n+1.5 and word 1 from the output-high-clock rising edge at n+2. `q_oe` is high for exactly that one cycle.
- R9: Outside the window of R8, `q_oe` is low and `q` is high impedance.
- R10: With `SINGLE_CLK`=1, read data is launched from `k`/`k_n` with the same timing, and `c`/`c_n` have no effect.
- R11: A read taken at the first legal edge after a write returns the data just written, including any masked lanes.
- R12: While `rst_n` is low at the clock edges, all pending commands are cleared. After reset, `q_oe` is low until a read is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| k | input | 1 | Input clock; commands and word 0 on its rising edge |
| k_n | input | 1 | Inverted input clock; word 1 on its rising edge |
| c | input | 1 | Output clock; launches word 1 |
| c_n | input | 1 | Inverted output clock; launches word 0 |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_n | input | 1 | Active-low load strobe |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W-ZERO_START | External word address |
| d | input | LANE_W*LANES | Write data |
| wmask_n | input | LANES | Active-low lane write masks |
| q | output | LANE_W*LANES | Read data, high impedance when idle |
| q_oe | output | 1 | High while `q` is driven |

## Verification
The bench builds two instances. The first is wide, with two 9-bit lanes, a 16-word array, `ZERO_START`=0 and separate output clocks, so both odd and even burst starts can be reached. The second is narrow, with two 4-bit lanes, `ZERO_START`=1 and `SINGLE_CLK`=1, and its `c`/`c_n` are tied low, so a correct read proves that the output clocks have no effect. Both instances share the command stream, so the spacing rule, mid-burst noise on `ld_n` and read-after-write are checked in both address layouts at the same time.

// File: rtl/b2_pkg.sv
// Package: shared types for the burst-of-two DDR SRAM core.
// Assumes: nothing beyond standard SystemVerilog.
package b2_pkg;
    // Operation held one k cycle after a command is taken.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } b2_op_e;
endpackage

// File: rtl/b2_cmd.sv
// Module: b2_cmd
// Takes commands on the rising edge of k, blocks the edge in the middle of
// a burst and produces a read strobe one cycle after a read and a commit
// strobe two cycles after a write, each with its internal word address.
// Assumes: ZERO_START is 0 or 1; all logic is clocked by k.
module b2_cmd
    import b2_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int ZERO_START = 0
) (
    input  logic                         k,
    input  logic                         rst_n,
    input  logic                         ld_n,
    input  logic                         rw,
    input  logic [ADDR_W-ZERO_START-1:0] ext_addr,
    output logic                         rd_go,
    output logic [ADDR_W-1:0]            rd_addr,
    output logic                         wr_go,
    output logic [ADDR_W-1:0]            wr_addr
);
    logic              mid;
    logic              accept;
    b2_op_e            op_q;
    logic              wr_stage2;
    logic [ADDR_W-1:0] int_addr;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_w2;

    // Internal address: the narrow layout forces bit 0 to zero.
    generate
        if (ZERO_START != 0) begin : g_zero
            assign int_addr = {ext_addr, 1'b0};
        end else begin : g_lsb
            assign int_addr = ext_addr;
        end
    endgenerate

    // A command counts only when the strobe is low outside a burst.
    assign accept = !ld_n && !mid;

    // Track the burst phase and pipeline the operation type.
    always_ff @(posedge k) begin
        if (!rst_n) begin
            mid       <= 1'b0;
            op_q      <= OP_IDLE;
            wr_stage2 <= 1'b0;
        end else begin
            mid       <= accept;
            op_q      <= accept ? (rw ? OP_READ : OP_WRITE) : OP_IDLE;
            wr_stage2 <= (op_q == OP_WRITE);
        end
    end

    // Hold the address of the taken command for the read and commit stages.
    always_ff @(posedge k) begin
        if (accept) begin
            addr_q <= int_addr;
        end
        addr_w2 <= addr_q;
    end

    assign rd_go   = (op_q == OP_READ);
    assign rd_addr = addr_q;
    assign wr_go   = wr_stage2;
    assign wr_addr = addr_w2;

    // R3: a taken command blocks the following edge.
    a_r3_cmd_gap: assert property (@(posedge k) disable iff (!rst_n)
        accept |=> !accept);
    // R1: a high strobe never leads to a read strobe.
    a_r1_idle_edge: assert property (@(posedge k) disable iff (!rst_n)
        ld_n |=> !rd_go);
    // R2: a taken write never produces a read strobe.
    a_r2_write_not_read: assert property (@(posedge k) disable iff (!rst_n)
        (accept && !rw) |=> !rd_go);
endmodule

// File: rtl/b2_wcap.sv
// Module: b2_wcap
// Captures the write bus on both input clock edges: the k copy serves as
// word 0, the k_n copy as word 1. Both are read by the array half a cycle
// or a full cycle later.
// Assumes: k_n is the inverse of k.
module b2_wcap #(
    parameter int DATA_W = 18,
    parameter int LANES  = 2
) (
    input  logic              k,
    input  logic              k_n,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] d,
    input  logic [LANES-1:0]  wmask_n,
    output logic [DATA_W-1:0] w0,
    output logic [LANES-1:0]  m0,
    output logic [DATA_W-1:0] w1,
    output logic [LANES-1:0]  m1
);
    // Word 0 and its mask on the rising edge of k.
    always_ff @(posedge k) begin
        if (!rst_n) begin
            w0 <= '0;
            m0 <= '1;
        end else begin
            w0 <= d;
            m0 <= wmask_n;
        end
    end

    // Word 1 and its mask on the rising edge of k_n.
    always_ff @(posedge k_n) begin
        if (!rst_n) begin
            w1 <= '0;
            m1 <= '1;
        end else begin
            w1 <= d;
            m1 <= wmask_n;
        end
    end
endmodule

// File: rtl/b2_array.sv
// Module: b2_array
// Storage array. It commits both words of a write burst in one k edge with
// per-lane enables, and reads both words of a read burst in one k edge.
// Assumes: commit and read strobes never coincide; word 1 lives at the
// address with bit 0 inverted.
module b2_array #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                      k,
    input  logic                      rst_n,
    input  logic                      wr_go,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANE_W*LANES-1:0]   w0,
    input  logic [LANES-1:0]          m0,
    input  logic [LANE_W*LANES-1:0]   w1,
    input  logic [LANES-1:0]          m1,
    input  logic                      rd_go,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic                      rd_vld,
    output logic [LANE_W*LANES-1:0]   rd_w0,
    output logic [LANE_W*LANES-1:0]   rd_w1
);
    localparam int DATA_W = LANE_W * LANES;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] FLIP = ADDR_W'(1);

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit the two words lane by lane, skipping masked lanes.
    always_ff @(posedge k) begin
        if (wr_go) begin
            for (int l = 0; l < LANES; l++) begin
                if (!m0[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= w0[l*LANE_W +: LANE_W];
                if (!m1[l]) mem[wr_addr ^ FLIP][l*LANE_W +: LANE_W] <= w1[l*LANE_W +: LANE_W];
            end
        end
    end

    // Fetch both words of a read burst into the output buffer.
    always_ff @(posedge k) begin
        if (rd_go) begin
            rd_w0 <= mem[rd_addr];
            rd_w1 <= mem[rd_addr ^ FLIP];
        end
    end

    // Flag that the output buffer holds a fresh burst.
    always_ff @(posedge k) begin
        if (!rst_n) rd_vld <= 1'b0;
        else        rd_vld <= rd_go;
    end

    // R7: a masked lane of word 0 keeps its stored value.
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_keep
            a_r7_lane_keep: assert property (@(posedge k) disable iff (!rst_n)
                (wr_go && m0[l]) |=>
                mem[$past(wr_addr)][l*LANE_W +: LANE_W] ==
                $past(mem[wr_addr][l*LANE_W +: LANE_W]));
        end
    endgenerate
endmodule

// File: rtl/b2_rdout.sv
// Module: b2_rdout
// Double-data-rate output stage. Word 0 is launched on the low output clock
// edge and word 1 on the next high edge; the bus is enabled for that cycle.
// Assumes: the launch clocks are inverses of each other and run in phase
// with k.
module b2_rdout #(
    parameter int DATA_W     = 18,
    parameter int SINGLE_CLK = 0
) (
    input  logic              k,
    input  logic              k_n,
    input  logic              c,
    input  logic              c_n,
    input  logic              rst_n,
    input  logic              rd_vld,
    input  logic [DATA_W-1:0] rd_w0,
    input  logic [DATA_W-1:0] rd_w1,
    output logic [DATA_W-1:0] q_int,
    output logic              q_oe
);
    logic              oclk;
    logic              oclk_n;
    logic [DATA_W-1:0] q_fall;
    logic [DATA_W-1:0] q_rise;
    logic [DATA_W-1:0] hold_w1;
    logic              oe_fall;
    logic              oe_rise;

    // Pick the launch clock pair.
    assign oclk   = (SINGLE_CLK != 0) ? k   : c;
    assign oclk_n = (SINGLE_CLK != 0) ? k_n : c_n;

    // Launch word 0 and park word 1 on the low-clock edge.
    always_ff @(posedge oclk_n) begin
        if (!rst_n) begin
            oe_fall <= 1'b0;
            q_fall  <= '0;
            hold_w1 <= '0;
        end else begin
            oe_fall <= rd_vld;
            q_fall  <= rd_w0;
            hold_w1 <= rd_w1;
        end
    end

    // Launch word 1 on the following high-clock edge.
    always_ff @(posedge oclk) begin
        if (!rst_n) begin
            oe_rise <= 1'b0;
            q_rise  <= '0;
        end else begin
            oe_rise <= oe_fall;
            q_rise  <= hold_w1;
        end
    end

    // Phase mux: high half shows word 1, low half shows word 0.
    assign q_int = oclk ? q_rise : q_fall;
    assign q_oe  = oclk ? oe_rise : oe_fall;

    // R9: read windows are separated by at least one idle cycle.
    a_r9_window_gap: assert property (@(posedge oclk) disable iff (!rst_n)
        oe_rise |=> !oe_rise);
endmodule

// File: rtl/burst2_ddr_sram.sv
// Module: burst2_ddr_sram (top)
// Burst-of-two DDR SRAM core: command tracker, dual-edge write capture,
// storage array and DDR output stage. Data bus is released when idle.
// Assumes: k_n = ~k, c_n = ~c; ZERO_START and SINGLE_CLK are 0 or 1.
module burst2_ddr_sram #(
    parameter int ADDR_W     = 6,
    parameter int LANE_W     = 9,
    parameter int LANES      = 2,
    parameter int ZERO_START = 0,
    parameter int SINGLE_CLK = 0
) (
    input  logic                         k,
    input  logic                         k_n,
    input  logic                         c,
    input  logic                         c_n,
    input  logic                         rst_n,
    input  logic                         ld_n,
    input  logic                         rw,
    input  logic [ADDR_W-ZERO_START-1:0] addr,
    input  logic [LANE_W*LANES-1:0]      d,
    input  logic [LANES-1:0]             wmask_n,
    output logic [LANE_W*LANES-1:0]      q,
    output logic                         q_oe
);
    localparam int DATA_W = LANE_W * LANES;

    logic              rd_go;
    logic              wr_go;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] w0;
    logic [DATA_W-1:0] w1;
    logic [LANES-1:0]  m0;
    logic [LANES-1:0]  m1;
    logic              rd_vld;
    logic [DATA_W-1:0] rd_w0;
    logic [DATA_W-1:0] rd_w1;
    logic [DATA_W-1:0] q_int;

    b2_cmd #(.ADDR_W(ADDR_W), .ZERO_START(ZERO_START)) u_cmd (
        .k(k), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .ext_addr(addr),
        .rd_go(rd_go), .rd_addr(rd_addr), .wr_go(wr_go), .wr_addr(wr_addr)
    );

    b2_wcap #(.DATA_W(DATA_W), .LANES(LANES)) u_wcap (
        .k(k), .k_n(k_n), .rst_n(rst_n), .d(d), .wmask_n(wmask_n),
        .w0(w0), .m0(m0), .w1(w1), .m1(m1)
    );

    b2_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .k(k), .rst_n(rst_n), .wr_go(wr_go), .wr_addr(wr_addr),
        .w0(w0), .m0(m0), .w1(w1), .m1(m1),
        .rd_go(rd_go), .rd_addr(rd_addr),
        .rd_vld(rd_vld), .rd_w0(rd_w0), .rd_w1(rd_w1)
    );

    b2_rdout #(.DATA_W(DATA_W), .SINGLE_CLK(SINGLE_CLK)) u_rdout (
        .k(k), .k_n(k_n), .c(c), .c_n(c_n), .rst_n(rst_n),
        .rd_vld(rd_vld), .rd_w0(rd_w0), .rd_w1(rd_w1),
        .q_int(q_int), .q_oe(q_oe)
    );

    // Release the data bus outside a read window.
    assign q = q_oe ? q_int : {DATA_W{1'bz}};

    // R3: commit and fetch strobes never meet, because bursts do not overlap.
    a_r3_no_overlap: assert property (@(posedge k) disable iff (!rst_n)
        rd_go |-> !wr_go);
endmodule

// File: tb/burst2_ddr_sram_bench.sv
module burst2_ddr_sram_bench;
    logic k = 1'b0;
    logic rst_n = 1'b0;
    logic ld_n = 1'b1;
    logic rw = 1'b1;
    logic [3:0] addr_w = '0;
    logic [2:0] addr_n = '0;
    logic [17:0] d_w = '0;
    logic [7:0]  d_n = '0;
    logic [1:0]  msk_w = '1;
    logic [1:0]  msk_n = '1;
    wire  [17:0] q_w;
    wire  [7:0]  q_n;
    logic oe_w, oe_n;
    logic k_n;
    assign k_n = ~k;

    always #10 k = ~k;

    burst2_ddr_sram #(.ADDR_W(4), .LANE_W(9), .LANES(2), .ZERO_START(0), .SINGLE_CLK(0))
    u_burst2_ddr_sram (
        .k(k), .k_n(k_n), .c(k), .c_n(k_n), .rst_n(rst_n), .ld_n(ld_n), .rw(rw),
        .addr(addr_w), .d(d_w), .wmask_n(msk_w), .q(q_w), .q_oe(oe_w));

    // R10: narrow single-clock instance with its output clocks tied low.
    burst2_ddr_sram #(.ADDR_W(4), .LANE_W(4), .LANES(2), .ZERO_START(1), .SINGLE_CLK(1))
    u_burst2_ddr_sram_nib (
        .k(k), .k_n(k_n), .c(1'b0), .c_n(1'b0), .rst_n(rst_n), .ld_n(ld_n), .rw(rw),
        .addr(addr_n), .d(d_n), .wmask_n(msk_n), .q(q_n), .q_oe(oe_n));

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    logic [17:0] mw [16];
    logic [7:0]  mn [16];
    bit          rdf [64];
    logic [17:0] ew0 [64];
    logic [17:0] ew1 [64];
    logic [7:0]  en0 [64];
    logic [7:0]  en1 [64];
    string       tagq [64];

    always @(posedge k) cyc++;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [17:0] mrg_w(input logic [17:0] old, input logic [17:0] nw, input logic [1:0] m);
        logic [17:0] r;
        r = old;
        for (int l = 0; l < 2; l++) if (!m[l]) r[l*9 +: 9] = nw[l*9 +: 9];
        return r;
    endfunction

    function automatic logic [7:0] mrg_n(input logic [7:0] old, input logic [7:0] nw, input logic [1:0] m);
        logic [7:0] r;
        r = old;
        for (int l = 0; l < 2; l++) if (!m[l]) r[l*4 +: 4] = nw[l*4 +: 4];
        return r;
    endfunction

    // Word 0 window: after the low-clock edge of the cycle after the command.
    always @(negedge k) begin : mon_fall
        int i;
        #5;
        if (mon_en) begin
            i = (cyc + 63) % 64;
            chk({tagq[i], " R8/R9 wide q_oe (word0 phase)"}, 32'(oe_w), 32'(rdf[i]));
            chk({tagq[i], " R8/R9 R10 narrow q_oe (word0 phase)"}, 32'(oe_n), 32'(rdf[i]));
            if (rdf[i]) begin
                chk({tagq[i], " R5 R8 wide word0"}, 32'(q_w), 32'(ew0[i]));
                chk({tagq[i], " R6 R10 narrow word0"}, 32'(q_n), 32'(en0[i]));
            end
        end
    end

    // Word 1 window: after the high-clock edge two cycles after the command.
    always @(posedge k) begin : mon_rise
        int i;
        #5;
        if (mon_en) begin
            i = (cyc + 62) % 64;
            chk({tagq[i], " R8/R9 wide q_oe (word1 phase)"}, 32'(oe_w), 32'(rdf[i]));
            chk({tagq[i], " R8/R9 R10 narrow q_oe (word1 phase)"}, 32'(oe_n), 32'(rdf[i]));
            if (rdf[i]) begin
                chk({tagq[i], " R5 R8 wide word1"}, 32'(q_w), 32'(ew1[i]));
                chk({tagq[i], " R6 R10 narrow word1"}, 32'(q_n), 32'(en1[i]));
            end
        end
    end

    task automatic junk();
        d_w = 18'($urandom);
        d_n = 8'($urandom);
        msk_w = 2'($urandom);
        msk_n = 2'($urandom);
    endtask

    // One idle k cycle with ld_n high; other inputs random (R1).
    task automatic idle(input string tag);
        ld_n = 1'b1;
        rw = 1'($urandom);
        addr_w = 4'($urandom);
        addr_n = 3'($urandom);
        junk();
        @(posedge k); #5;
        rdf[cyc % 64] = 1'b0;
        tagq[cyc % 64] = tag;
        @(negedge k); #5;
    endtask

    // One command over two k cycles; called and returns at negedge + 5.
    task automatic op(input bit rd, input logic [3:0] aw, input logic [2:0] an,
                      input logic [1:0] m0w, input logic [1:0] m1w,
                      input logic [1:0] m0n, input logic [1:0] m1n,
                      input bit noise, input string tag);
        logic [17:0] w0w, w1w;
        logic [7:0]  w0n, w1n;
        int idx;
        w0w = 18'($urandom); w1w = 18'($urandom);
        w0n = 8'($urandom);  w1n = 8'($urandom);
        ld_n = 1'b0; rw = rd; addr_w = aw; addr_n = an;
        junk();
        @(posedge k); #5;
        idx = cyc % 64;
        rdf[idx] = rd;
        tagq[idx] = tag;
        if (rd) begin
            ew0[idx] = mw[aw];
            ew1[idx] = mw[aw ^ 4'd1];
            en0[idx] = mn[{an, 1'b0}];
            en1[idx] = mn[{an, 1'b1}];
        end else begin
            mw[aw]         = mrg_w(mw[aw], w0w, m0w);
            mw[aw ^ 4'd1]  = mrg_w(mw[aw ^ 4'd1], w1w, m1w);
            mn[{an, 1'b0}] = mrg_n(mn[{an, 1'b0}], w0n, m0n);
            mn[{an, 1'b1}] = mrg_n(mn[{an, 1'b1}], w1n, m1n);
        end
        // R3: optional strobe noise on the mid-burst edge.
        ld_n = !noise;
        rw = 1'($urandom);
        addr_w = 4'($urandom);
        addr_n = 3'($urandom);
        @(negedge k); #5;
        d_w = rd ? 18'($urandom) : w0w;
        d_n = rd ? 8'($urandom) : w0n;
        msk_w = rd ? 2'($urandom) : m0w;
        msk_n = rd ? 2'($urandom) : m0n;
        @(posedge k); #5;
        idx = cyc % 64;
        rdf[idx] = 1'b0;
        tagq[idx] = noise ? {tag, " R3 mid-burst ld_n ignored"} : tag;
        ld_n = 1'b1;
        d_w = rd ? 18'($urandom) : w1w;
        d_n = rd ? 8'($urandom) : w1n;
        msk_w = rd ? 2'($urandom) : m1w;
        msk_n = rd ? 2'($urandom) : m1n;
        @(negedge k); #5;
        junk();
    endtask

    initial begin
        void'($urandom(32'd5281));
        for (int i = 0; i < 64; i++) begin
            rdf[i] = 1'b0;
            tagq[i] = "R12 reset";
        end
        for (int i = 0; i < 16; i++) begin
            mw[i] = '0;
            mn[i] = '0;
        end
        repeat (4) @(posedge k);
        @(negedge k); #5;
        rst_n = 1'b1;
        chk("R12 wide q_oe after reset", 32'(oe_w), 32'd0);
        chk("R12 narrow q_oe after reset", 32'(oe_n), 32'd0);
        mon_en = 1'b1;

        // R4: fill every address with full-mask writes.
        for (int a = 0; a < 8; a++)
            op(1'b0, {3'(a), 1'b0}, 3'(a), 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, "R4 fill");

        // R5: odd and even burst starts.
        op(1'b1, 4'd5, 3'd2, 2'b11, 2'b11, 2'b11, 2'b11, 1'b0, "R5 odd start");
        op(1'b1, 4'd4, 3'd3, 2'b11, 2'b11, 2'b11, 2'b11, 1'b0, "R5 even start");

        // R7 and R11: masked write followed at once by a read of the same pair.
        op(1'b0, 4'd6, 3'd1, 2'b10, 2'b01, 2'b01, 2'b10, 1'b0, "R7 lane mask write");
        op(1'b1, 4'd6, 3'd1, 2'b11, 2'b11, 2'b11, 2'b11, 1'b0, "R11 read after write");
        op(1'b1, 4'd7, 3'd1, 2'b11, 2'b11, 2'b11, 2'b11, 1'b0, "R5 R7 odd reread");

        // R7: all lanes masked changes nothing.
        op(1'b0, 4'd9, 3'd4, 2'b11, 2'b11, 2'b11, 2'b11, 1'b0, "R7 all masked");
        op(1'b1, 4'd9, 3'd4, 2'b11, 2'b11, 2'b11, 2'b11, 1'b0, "R7 R11 all masked readback");

        // R3: back-to-back reads with noise on every mid-burst edge.
        op(1'b1, 4'd2, 3'd5, 2'b11, 2'b11, 2'b11, 2'b11, 1'b1, "R3 back-to-back");
        op(1'b1, 4'd11, 3'd6, 2'b11, 2'b11, 2'b11, 2'b11, 1'b1, "R3 back-to-back");

        // R1: idle cycles with random direction and data, then readback.
        repeat (4) idle("R1 ld_n high");
        op(1'b1, 4'd0, 3'd0, 2'b11, 2'b11, 2'b11, 2'b11, 1'b0, "R1 readback");
        op(1'b1, 4'd13, 3'd7, 2'b11, 2'b11, 2'b11, 2'b11, 1'b0, "R1 readback");

        // R2: random mix of reads, writes, masks, noise and idles.
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 4) == 0) idle("R1 random idle");
            op(1'($urandom), 4'($urandom), 3'($urandom),
               2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
               1'($urandom), "R2 random");
        end
        repeat (3) idle("R9 drain");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge k);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule